// File: doc/BRIEF.md
# Multichannel Acquisition Sequencer

This block runs the acquisition loop of an eight-input data logger without software in the loop. It drives a five-bit control port that feeds an external analog multiplexer, a sample-and-hold stage and an 8-bit converter. For each conversion it selects the channel and lets it settle. It then freezes the sample and fires a convert pulse. It waits for the converter's active-low end-of-conversion line and latches the converted byte. Last, it releases the hold and raises an interrupt that carries the value and its channel number.

While `runEn` is high the loop repeats without a break. In scan mode it walks through the channels whose enable bit is set, in ascending order, and wraps around. In repeat mode it keeps converting one channel. A result stays on the outputs until the interrupt is acknowledged. A second result that arrives first is flagged as an overrun. A conversion whose end signal never comes is abandoned after a fixed number of cycles, and an error flag is set.

Top module: `acq_sequencer`

## Requirements
- R1: `ctrlPort` carries the channel number on bits 4:2, the sample/hold level on bit 1 (1 = track, 0 = hold) and the convert pulse on bit 0. After reset it reads channel 0, track, no pulse, and `irq`, `overrun` and `timeoutErr` are 0.
- R2: Bit 1 falls exactly HOLD_SETUP cycles (default 2) before bit 0 rises. Bit 0 is 1 only while bit 1 is 0. The channel bits do not change while bit 1 is 0.
- R3: The convert pulse lasts `pulseCycles` clock cycles. A value of 0 gives a one-cycle pulse.
- R4: Between two back-to-back conversions, bit 1 stays at 1 for exactly `settleCycles`+2 cycles: one release cycle plus `settleCycles`+1 settle cycles with the new channel on bits 4:2.
- R5: At the first clock edge that samples `eocN` low after the pulse, `adcData` and the channel are latched into `sampleData`/`sampleChan`, `irq` is set and bit 1 returns to 1.
- R6: In scan mode (`scanMode`=1) the first conversion uses the lowest channel whose `chanMask` bit is 1. Each later conversion uses the next enabled channel above the current one and wraps from the top back to the lowest enabled channel. Disabled channels are never selected.
- R7: In repeat mode (`scanMode`=0) every conversion of a run uses the lowest enabled channel at start.
- R8: `irq` stays 1 until `intAck` is sampled high. That edge clears `irq`, `overrun` and `timeoutErr`.
- R9: A result or a timeout that arrives while `irq` is still set and `intAck` is low sets `overrun`.
- R10: If `eocN` stays high for TIMEOUT cycles (default 64) after the pulse ends, the conversion is abandoned. `timeoutErr` and `irq` are set, `sampleChan` takes the channel, `sampleData` keeps its old value and bit 1 returns to 1.
- R11: When `runEn` is low at a release, the sequencer goes idle (track, no pulse) and starts nothing more. With `chanMask` all zero, no conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Keep acquiring while high |
| scanMode | input | 1 | 1 = scan enabled channels, 0 = repeat one channel |
| chanMask | input | 8 | Per-channel enable |
| settleCycles | input | 8 | Channel settle delay setting |
| pulseCycles | input | 4 | Convert pulse width setting |
| eocN | input | 1 | Converter end of conversion, active low |
| adcData | input | 8 | Converter output byte |
| intAck | input | 1 | Interrupt acknowledge |
| ctrlPort | output | 5 | {channel[2:0], sample/hold, convert} |
| sampleData | output | 8 | Latched conversion value |
| sampleChan | output | 3 | Channel of the latched result |
| irq | output | 1 | Result pending |
| overrun | output | 1 | Result lost to a newer one |
| timeoutErr | output | 1 | Last conversion timed out |

## Verification
Each result is due at the first falling clock edge after the rising edge that samples `eocN` low. That is the same edge at which bit 1 returns to 1, so the bench checks the latched value, channel and flags exactly when it sees the hold release. The hold setup, pulse width, settle gap and timeout window are measured from the port bits by counting falling-edge samples. The bench compares them with the configured settings. An acknowledge driven at one falling edge must show cleared flags at the next falling edge. After a stop, the bench expects exactly one more conversion, because the stop is seen at the edge that starts the next settle.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_HOLD,
    ST_CONV,
    ST_WAIT,
    ST_RELEASE
  } acqState_t;

  typedef struct packed {
    logic loadFirst;
    logic advance;
    logic capture;
    logic timeout;
  } acqStrobe_t;

endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int SETTLE_W   = 8,
  parameter int PULSE_W    = 4,
  parameter int HOLD_SETUP = 2,
  parameter int TIMEOUT    = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic                anyEnabled,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic [PULSE_W-1:0]  pulseCycles,
  input  logic                eocN,
  output logic                shTrack,
  output logic                convPulse,
  output acqStrobe_t          strobe
);

  localparam int TO_W  = $clog2(TIMEOUT);
  localparam int HS_W  = $clog2(HOLD_SETUP) + 1;
  localparam int W_A   = (SETTLE_W > PULSE_W) ? SETTLE_W : PULSE_W;
  localparam int W_B   = (W_A > TO_W) ? W_A : TO_W;
  localparam int CNT_W = (W_B > HS_W) ? W_B : HS_W;

  acqState_t state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic cntZero;

  assign cntZero = (cnt == '0);

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (runEn && anyEnabled) begin
          strobe.loadFirst = 1'b1;
          stateNxt = ST_SETTLE;
          cntNxt   = CNT_W'(settleCycles);
        end
      end
      ST_SETTLE: begin
        if (cntZero) begin
          stateNxt = ST_HOLD;
          cntNxt   = CNT_W'(HOLD_SETUP - 1);
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      ST_HOLD: begin
        if (cntZero) begin
          stateNxt = ST_CONV;
          cntNxt   = (pulseCycles == '0) ? '0 : CNT_W'(pulseCycles) - CNT_W'(1);
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      ST_CONV: begin
        if (cntZero) begin
          stateNxt = ST_WAIT;
          cntNxt   = '0;
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      ST_WAIT: begin
        if (!eocN) begin
          strobe.capture = 1'b1;
          stateNxt = ST_RELEASE;
        end else if (cnt == CNT_W'(TIMEOUT - 1)) begin
          strobe.timeout = 1'b1;
          stateNxt = ST_RELEASE;
        end else begin
          cntNxt = cnt + CNT_W'(1);
        end
      end
      ST_RELEASE: begin
        if (runEn && anyEnabled) begin
          strobe.advance = 1'b1;
          stateNxt = ST_SETTLE;
          cntNxt   = CNT_W'(settleCycles);
        end else begin
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  assign shTrack   = !(state == ST_HOLD || state == ST_CONV || state == ST_WAIT);
  assign convPulse = (state == ST_CONV);

  AST_RELEASE_ON_EOC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !eocN) |=> (shTrack && !convPulse)); // R5

  AST_HOLD_BEFORE_CONV: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convPulse) |-> ($past(!shTrack) && !shTrack)); // R2

endmodule

// File: rtl/acq_datapath.sv
module acq_datapath
  import acq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       scanMode,
  input  logic [NUM_CH-1:0]          chanMask,
  input  logic [DATA_W-1:0]          adcData,
  input  logic                       intAck,
  input  acqStrobe_t                 strobe,
  output logic                       anyEnabled,
  output logic [$clog2(NUM_CH)-1:0]  chanSel,
  output logic [DATA_W-1:0]          sampleData,
  output logic [$clog2(NUM_CH)-1:0]  sampleChan,
  output logic                       irq,
  output logic                       overrun,
  output logic                       timeoutErr
);

  localparam int CH_W = $clog2(NUM_CH);

  logic [CH_W-1:0] chanReg, lowestChan, nextChan;
  logic            nextFound;
  logic            resultIn;

  always_comb begin
    lowestChan = '0;
    anyEnabled = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (chanMask[i]) begin
        lowestChan = CH_W'(i);
        anyEnabled = 1'b1;
      end
    end
  end

  always_comb begin
    nextChan  = chanReg;
    nextFound = 1'b0;
    for (int k = 1; k <= NUM_CH; k++) begin
      if (!nextFound && chanMask[(int'(chanReg) + k) % NUM_CH]) begin
        nextFound = 1'b1;
        nextChan  = CH_W'((int'(chanReg) + k) % NUM_CH);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanReg <= '0;
    end else if (strobe.loadFirst) begin
      chanReg <= lowestChan;
    end else if (strobe.advance && scanMode) begin
      chanReg <= nextChan;
    end
  end

  assign resultIn = strobe.capture | strobe.timeout;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleData <= '0;
      sampleChan <= '0;
      irq        <= 1'b0;
      overrun    <= 1'b0;
      timeoutErr <= 1'b0;
    end else if (resultIn) begin
      sampleChan <= chanReg;
      irq        <= 1'b1;
      overrun    <= (overrun | irq) & ~intAck;
      if (strobe.capture) begin
        sampleData <= adcData;
        timeoutErr <= timeoutErr & ~intAck;
      end else begin
        timeoutErr <= 1'b1;
      end
    end else if (intAck) begin
      irq        <= 1'b0;
      overrun    <= 1'b0;
      timeoutErr <= 1'b0;
    end
  end

  assign chanSel = chanReg;

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !intAck && resultIn) |=> overrun); // R9

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int DATA_W     = 8,
  parameter int SETTLE_W   = 8,
  parameter int PULSE_W    = 4,
  parameter int HOLD_SETUP = 2,
  parameter int TIMEOUT    = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        runEn,
  input  logic                        scanMode,
  input  logic [NUM_CH-1:0]           chanMask,
  input  logic [SETTLE_W-1:0]         settleCycles,
  input  logic [PULSE_W-1:0]          pulseCycles,
  input  logic                        eocN,
  input  logic [DATA_W-1:0]           adcData,
  input  logic                        intAck,
  output logic [$clog2(NUM_CH)+1:0]   ctrlPort,
  output logic [DATA_W-1:0]           sampleData,
  output logic [$clog2(NUM_CH)-1:0]   sampleChan,
  output logic                        irq,
  output logic                        overrun,
  output logic                        timeoutErr
);

  localparam int CH_W = $clog2(NUM_CH);

  acqStrobe_t      strobe;
  logic            anyEnabled;
  logic            shTrack;
  logic            convPulse;
  logic [CH_W-1:0] chanSel;

  acq_ctrl #(
    .SETTLE_W  (SETTLE_W),
    .PULSE_W   (PULSE_W),
    .HOLD_SETUP(HOLD_SETUP),
    .TIMEOUT   (TIMEOUT)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .runEn       (runEn),
    .anyEnabled  (anyEnabled),
    .settleCycles(settleCycles),
    .pulseCycles (pulseCycles),
    .eocN        (eocN),
    .shTrack     (shTrack),
    .convPulse   (convPulse),
    .strobe      (strobe)
  );

  acq_datapath #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .scanMode  (scanMode),
    .chanMask  (chanMask),
    .adcData   (adcData),
    .intAck    (intAck),
    .strobe    (strobe),
    .anyEnabled(anyEnabled),
    .chanSel   (chanSel),
    .sampleData(sampleData),
    .sampleChan(sampleChan),
    .irq       (irq),
    .overrun   (overrun),
    .timeoutErr(timeoutErr)
  );

  assign ctrlPort = {chanSel, shTrack, convPulse};

  AST_CHAN_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!shTrack && $past(!shTrack)) |-> $stable(chanSel)); // R2

  AST_CONV_IN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    convPulse |-> !shTrack); // R2

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !intAck) |=> irq); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !strobe.capture && !strobe.timeout) |=> (!irq && !overrun && !timeoutErr)); // R8

endmodule

// File: tb/acq_sequencer_bench.sv
module acq_sequencer_bench;

  localparam int HS  = 2;
  localparam int TMO = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0;
  logic       scanMode = 1'b1;
  logic [7:0] chanMask = 8'h00;
  logic [7:0] settleCycles = 8'd0;
  logic [3:0] pulseCycles = 4'd0;
  logic       eocN = 1'b1;
  logic [7:0] adcData = 8'h00;
  logic       intAck = 1'b0;
  logic [4:0] ctrlPort;
  logic [7:0] sampleData;
  logic [2:0] sampleChan;
  logic       irq, overrun, timeoutErr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  bit muteEoc = 1'b0;
  bit autoAck = 1'b1;
  int releaseCount = 0;
  int convStarts = 0;

  acq_sequencer #(.HOLD_SETUP(HS), .TIMEOUT(TMO)) u_acq_sequencer (
    .clk(clk), .rstN(rstN), .runEn(runEn), .scanMode(scanMode),
    .chanMask(chanMask), .settleCycles(settleCycles), .pulseCycles(pulseCycles),
    .eocN(eocN), .adcData(adcData), .intAck(intAck), .ctrlPort(ctrlPort),
    .sampleData(sampleData), .sampleChan(sampleChan), .irq(irq),
    .overrun(overrun), .timeoutErr(timeoutErr)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowestRef(logic [7:0] m);
    int r = 0;
    for (int i = 7; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

  function automatic int nextRef(int cur, logic [7:0] m, bit scan);
    if (!scan) return cur;
    for (int d = 1; d <= 8; d++) if (m[(cur + d) & 7]) return (cur + d) & 7;
    return cur;
  endfunction

  // Monitor, converter model and acknowledge, all at the falling edge
  initial begin
    bit prevSh = 1'b1, prevCv = 1'b0, convSeen = 1'b0, gapValid = 1'b0;
    bit pendIrq = 1'b0, pendOv = 1'b0, pendTo = 1'b0;
    int shHighRun = 0, holdCnt = 0, convCnt = 0, waitCnt = 0;
    int holdChan = 0, expNext = 0, eocCountdown = -1;
    logic [7:0] expData = 8'h00, lastData = 8'h00;
    forever begin
      @(negedge clk);
      if (rstN) begin
        bit sh, cv;
        int ch;
        sh = ctrlPort[1];
        cv = ctrlPort[0];
        ch = int'(ctrlPort[4:2]);
        if (intAck) begin
          intAck = 1'b0;
          pendIrq = 1'b0; pendOv = 1'b0; pendTo = 1'b0;
          chk(!irq && !overrun && !timeoutErr, "R8 ack clears flags",
              int'({irq, overrun, timeoutErr}), 0);
        end
        if (sh && !prevSh) begin
          pendOv = pendOv | pendIrq;
          pendIrq = 1'b1;
          chk(irq == 1'b1, "R5 irq at release", int'(irq), 1);
          chk(int'(sampleChan) == holdChan, "R5 result channel", int'(sampleChan), holdChan);
          chk(overrun == pendOv, "R9 overrun flag", int'(overrun), int'(pendOv));
          if (muteEoc) begin
            pendTo = 1'b1;
            chk(waitCnt == TMO, "R10 timeout window", waitCnt, TMO);
            chk(sampleData == lastData, "R10 data kept", int'(sampleData), int'(lastData));
          end else begin
            chk(sampleData == expData, "R5 captured data", int'(sampleData), int'(expData));
            lastData = expData;
          end
          chk(timeoutErr == pendTo, "R10 timeout flag", int'(timeoutErr), int'(pendTo));
          releaseCount++;
          gapValid = 1'b1;
          expNext = nextRef(holdChan, chanMask, scanMode);
          shHighRun = 0;
          eocN = 1'b1;
          eocCountdown = -1;
        end
        if (sh) begin
          shHighRun++;
          if (shHighRun > int'(settleCycles) + 2) gapValid = 1'b0;
        end
        if (!sh && prevSh) begin
          int e;
          e = gapValid ? expNext : lowestRef(chanMask);
          chk(ch == e, "R6/R7 channel order", ch, e);
          chk(chanMask[ch] == 1'b1, "R6 enabled channel only", int'(chanMask[ch]), 1);
          if (gapValid)
            chk(shHighRun == int'(settleCycles) + 2, "R4 settle gap",
                shHighRun, int'(settleCycles) + 2);
          holdChan = ch;
          holdCnt = 0; convSeen = 1'b0; waitCnt = 0;
          expData = 8'($urandom);
          adcData = expData;
        end
        if (!sh) begin
          if (ch != holdChan) chk(1'b0, "R2 channel steady in hold", ch, holdChan);
          if (!cv && !convSeen) holdCnt++;
          if (!cv && convSeen) waitCnt++;
        end
        if (cv && sh) chk(1'b0, "R2 pulse outside hold", 1, 0);
        if (cv && !prevCv) begin
          chk(holdCnt == HS, "R2 hold setup", holdCnt, HS);
          convCnt = 0; convSeen = 1'b1; convStarts++;
        end
        if (cv) convCnt++;
        if (!cv && prevCv) begin
          int ew;
          ew = (pulseCycles == 0) ? 1 : int'(pulseCycles);
          chk(convCnt == ew, "R3 pulse width", convCnt, ew);
          eocCountdown = muteEoc ? -1 : int'($urandom_range(0, 5));
        end
        if (eocCountdown == 0) begin
          eocN = 1'b0;
          eocCountdown = -1;
        end else if (eocCountdown > 0) begin
          eocCountdown--;
        end
        if (!intAck && autoAck && pendIrq) intAck = 1'b1;
        prevSh = sh;
        prevCv = cv;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // n conversions, stop, then exactly one more must finish
  task automatic burst(input logic [7:0] m, input bit scan, input int settle,
                       input int pulse, input int n);
    int target;
    chanMask = m; scanMode = scan;
    settleCycles = 8'(settle); pulseCycles = 4'(pulse);
    target = releaseCount + n;
    runEn = 1'b1;
    while (releaseCount < target) step(1);
    runEn = 1'b0;
    step(300);
    chk(releaseCount == target + 1, "R11 stop after one more", releaseCount, target + 1);
    chk(ctrlPort[1:0] == 2'b10, "R11 idle port", int'(ctrlPort[1:0]), 2);
  endtask

  initial begin
    int seedSink;
    seedSink = $urandom(32'd1357);
    step(4);
    chk(ctrlPort == 5'b00010, "R1 port in reset", int'(ctrlPort), 2);
    rstN = 1'b1;
    step(2);
    chk(ctrlPort == 5'b00010, "R1 port after reset", int'(ctrlPort), 2);
    chk({irq, overrun, timeoutErr} == 3'b000, "R1 flags after reset",
        int'({irq, overrun, timeoutErr}), 0);

    // R11: empty mask never starts
    chanMask = 8'h00; runEn = 1'b1;
    step(60);
    chk(convStarts == 0, "R11 empty mask idle", convStarts, 0);
    runEn = 1'b0;

    // R6: skip and wrap over channels 2, 5, 7 with a one-cycle pulse
    burst(8'b1010_0100, 1'b1, 3, 0, 7);
    // R6: top channel only and channel 0 neighbour wrap
    burst(8'b1000_0001, 1'b1, 0, 1, 5);
    // R7: repeat mode on channel 3
    burst(8'b0001_1000, 1'b0, 2, 3, 4);

    // R9: no acknowledge, the second result overruns
    autoAck = 1'b0;
    burst(8'b0100_0000, 1'b1, 1, 2, 1);
    chk(overrun == 1'b1, "R9 overrun held", int'(overrun), 1);
    chk(irq == 1'b1, "R8 irq held without ack", int'(irq), 1);
    autoAck = 1'b1;
    step(5);
    chk(irq == 1'b0, "R8 irq cleared by ack", int'(irq), 0);

    // R10: converter never answers
    muteEoc = 1'b1;
    burst(8'b0100_0000, 1'b1, 2, 1, 1);
    muteEoc = 1'b0;
    step(5);

    // Random configurations
    for (int r = 0; r < 12; r++) begin
      logic [7:0] m;
      m = 8'($urandom);
      if (m == 8'h00) m = 8'h10;
      burst(m, 1'($urandom), int'($urandom_range(0, 6)),
            int'($urandom_range(0, 4)), int'($urandom_range(3, 6)));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", releaseCount, -1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule